// File: doc/BRIEF.md
# USB Host Interrupt Enable Aggregator

This block folds six host-controller event sources into a single interrupt line. Each source has a sticky status flag, set by a one-cycle strobe from the controller core and cleared by software writing a 1 to it. Each source also has an enable bit. A status flag always records its event, even when its enable is off, so software can poll for it. Only enabled flags can drive the interrupt line.

Three sources (host system error, frame list rollover, port change) are urgent. They reach the interrupt line as soon as they are pending and enabled. The other three (async advance, USB error, transaction complete) are deferred. They are held until the next interrupt-threshold boundary. A counter advanced by a microframe tick produces that boundary every 2^code ticks, where the code is programmed by software.

Software reaches three registers through a simple register port. It has a register select, a write strobe, write data, and read data that is combinational on the select. The status, enable and threshold pins are plain control signals with no handshake.

Top module: `usb_irq_combiner`

## Requirements
- R1: After reset the status register reads 0, the enable register reads 0, the threshold code reads 3, and `irq_o` is 0. `irq_o` is held at 0 while reset is asserted.
- R2: Register select 1 is the enable register. Its bits 5:0 are writable, and bits 31:6 ignore writes and read as 0. Register select 2 is the threshold code. Its bits 2:0 are writable, and bits 31:3 read as 0. Register select 0 is status, with the flags in bits 5:0 and bits 31:6 reading 0.
- R3: A one-cycle strobe on `evt_set[i]` sets status bit i at the next rising edge, whatever enable bit i holds. A source whose enable bit is 0 never raises `irq_o`.
- R4: Writing to register select 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R5: When a strobe and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R6: The urgent sources are bits 4, 3 and 2. When such a bit is pending and enabled, `irq_o` is 1 at the rising edge after the one that set the status bit, with no wait for a boundary.
- R7: The deferred sources are bits 5, 1 and 0. A pending and enabled deferred bit raises `irq_o` only after a threshold boundary occurs while the bit is already set in status. `irq_o` rises one edge after the boundary edge. The bit stays released until its status is cleared.
- R8: A boundary occurs on the tick that completes 2^code ticks. Codes 0 to 6 give 1 to 64 ticks, and code 7 behaves as 64. The tick count restarts after each boundary and on every write to the threshold register.
- R9: A deferred bit that software clears before a boundary arrives produces no interrupt.
- R10: `irq_o` stays 1 until every enabled pending source has been cleared. It falls one edge after the last of them is cleared.
- R11: Clearing an enable bit removes that source's contribution to `irq_o` one edge later. The status bit itself is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 threshold |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| evt_set | input | 6 | One-cycle event strobes from the controller core |
| ufr_tick | input | 1 | One-cycle microframe tick |
| irq_o | output | 1 | Registered host interrupt |

## Verification
The bench pulses each deferred source and counts ticks up to the threshold. It checks that the interrupt stays low through the tick before the boundary and rises right after it; a counter off by one would fire a tick early or a tick late. It also checks that code 7 saturates at 64 ticks, and that a deferred flag cleared before its boundary never fires; a release latch that ignored status would raise a stray interrupt there. A strobe that coincides with a clear must leave the bit set. Disabled flags must stay visible in status while the line stays low, which catches gating applied to status rather than to the output.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int SRC_N = 6;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_THRESH = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
  // urgent sources raise the line at once, deferred ones wait for a boundary
  localparam logic [SRC_N-1:0] URGENT_MASK   = 6'b011100;
  localparam logic [SRC_N-1:0] DEFERRED_MASK = 6'b100011;
  localparam logic [2:0]       THRESH_RESET  = 3'd3;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat_o[i] <= 1'b0;
      else if (set_i[i]) stat_o[i] <= 1'b1;   // set beats clear
      else if (clr_i[i]) stat_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_thresh_timer.sv
module irq_thresh_timer #(
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic              restart_i,
  input  logic              tick_i,
  output logic              bnd_o
);
  localparam int CNT_W = MAX_CODE + 1;
  localparam logic [CODE_W-1:0] CODE_CAP = CODE_W'(MAX_CODE);

  logic [CODE_W-1:0] code_eff;
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  cnt_q;

  always_comb begin
    code_eff = (code_i > CODE_CAP) ? CODE_CAP : code_i;
    limit    = CNT_W'(1) << code_eff;
  end

  assign bnd_o = tick_i && (cnt_q >= limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i) begin
      if (bnd_o) cnt_q <= '0;
      else       cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/irq_defer_gate.sv
module irq_defer_gate #(
  parameter int              N        = 6,
  parameter logic [N-1:0]    DEF_MASK = 6'b100011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  input  logic         bnd_i,
  output logic         irq_o
);
  logic [N-1:0] armed;

  for (genvar i = 0; i < N; i++) begin : g_src
    if (DEF_MASK[i]) begin : g_def
      logic rel_q;
      // released at a boundary while pending, dropped once status clears
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rel_q <= 1'b0;
        else        rel_q <= stat_i[i] & (rel_q | bnd_i);
      end
      assign armed[i] = rel_q;
    end else begin : g_imm
      assign armed[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(stat_i & en_i & armed);
  end
endmodule

// File: rtl/usb_irq_combiner.sv
module usb_irq_combiner
  import usb_irq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [SRC_N-1:0]    evt_set,
  input  logic                ufr_tick,
  output logic                irq_o
);
  reg_sel_e           sel;
  logic               wr_stat, wr_en, wr_thr;
  logic [SRC_N-1:0]   stat_q;
  logic [SRC_N-1:0]   en_q;
  logic [CODE_W-1:0]  code_q;
  logic               bnd;
  logic               wdata_unused;

  assign sel     = reg_sel_e'(reg_addr);
  assign wr_stat = reg_wr && (sel == SEL_STATUS);
  assign wr_en   = reg_wr && (sel == SEL_ENABLE);
  assign wr_thr  = reg_wr && (sel == SEL_THRESH);
  assign wdata_unused = ^reg_wdata[DATA_W-1:SRC_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= reg_wdata[SRC_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= CODE_W'(THRESH_RESET);
    else if (wr_thr) code_q <= reg_wdata[CODE_W-1:0];
  end

  irq_status_bank #(.N(SRC_N)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_set),
    .clr_i  (wr_stat ? reg_wdata[SRC_N-1:0] : '0),
    .stat_o (stat_q)
  );

  irq_thresh_timer #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_i    (code_q),
    .restart_i (wr_thr),
    .tick_i    (ufr_tick),
    .bnd_o     (bnd)
  );

  irq_defer_gate #(.N(SRC_N), .DEF_MASK(DEFERRED_MASK)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_i (stat_q),
    .en_i   (en_q),
    .bnd_i  (bnd),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: rd_data = DATA_W'(stat_q);
      SEL_ENABLE: rd_data = DATA_W'(en_q);
      SEL_THRESH: rd_data = DATA_W'(code_q);
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/usb_irq_combiner_chk.sv
module usb_irq_combiner_chk
  import usb_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic             reg_wr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      rd_data,
  input logic [SRC_N-1:0] evt_set,
  input logic             ufr_tick,
  input logic             irq_o,
  input logic [SRC_N-1:0] stat,
  input logic [SRC_N-1:0] en,
  input logic             bnd
);
  assert_irq_low_in_reset_R1: assert property (@(posedge clk) !rst_n |-> !irq_o);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != 2'd2) |-> (rd_data[31:SRC_N] == '0));

  assert_set_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((stat & $past(evt_set)) == $past(evt_set)));

  assert_w1c_keeps_zeros_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=>
      ((stat & ~$past(reg_wdata[SRC_N-1:0])) ==
       (($past(stat) | $past(evt_set)) & ~$past(reg_wdata[SRC_N-1:0]))));

  assert_urgent_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & en & URGENT_MASK)) |=> irq_o);

  assert_needs_enabled_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(stat & en)));

  assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !irq_o);

  assert_boundary_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |-> ufr_tick);
endmodule

bind usb_irq_combiner usb_irq_combiner_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .rd_data   (rd_data),
  .evt_set   (evt_set),
  .ufr_tick  (ufr_tick),
  .irq_o     (irq_o),
  .stat      (stat_q),
  .en        (en_q),
  .bnd       (bnd)
);

// File: tb/sim_usb_irq_combiner.sv
`timescale 1ns/1ps
module sim_usb_irq_combiner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_data;
  logic [5:0]  evt_set = '0;
  logic        ufr_tick = 1'b0;
  logic        irq_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_irq_combiner u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .evt_set(evt_set),
    .ufr_tick(ufr_tick), .irq_o(irq_o)
  );

  // {enable[5:0], events[5:0], expected irq}; no ticks, so deferred bits stay quiet
  localparam logic [12:0] VEC [10] = '{
    {6'h3F, 6'h04, 1'b1}, {6'h3F, 6'h08, 1'b1}, {6'h3F, 6'h10, 1'b1},
    {6'h00, 6'h1C, 1'b0}, {6'h3F, 6'h01, 1'b0}, {6'h3F, 6'h22, 1'b0},
    {6'h0B, 6'h14, 1'b0}, {6'h0B, 6'h1C, 1'b1}, {6'h10, 6'h10, 1'b1},
    {6'h23, 6'h23, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = rd_data;
  endtask

  task automatic pulse(input logic [5:0] m);
    @(negedge clk); evt_set = m;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic tick();
    @(negedge clk); ufr_tick = 1'b1;
    @(negedge clk); ufr_tick = 1'b0;
  endtask

  task automatic clear_all();
    wr(2'd0, 32'h3F); @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 32'(irq_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d); chk("R1 status reset", d, 0);
    rd(2'd1, d); chk("R1 enable reset", d, 0);
    rd(2'd2, d); chk("R1 thresh reset", d, 3);
    chk("R1 irq after reset", 32'(irq_o), 0);

    // table walk: urgent versus deferred, enable gating
    for (int k = 0; k < 10; k++) begin
      clear_all();
      wr(2'd1, 32'(VEC[k][12:7]));
      pulse(VEC[k][6:1]);
      @(negedge clk);
      rd(2'd0, d); chk($sformatf("R3 status vec%0d", k), d, 32'(VEC[k][6:1]));
      chk($sformatf("R6 irq vec%0d", k), 32'(irq_o), 32'(VEC[k][0]));
    end

    // R2 reserved bits
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R2 enable reserved", d, 32'h3F);
    wr(2'd2, 32'hFFFF_FFF8); rd(2'd2, d); chk("R2 thresh reserved", d, 0);

    // R4 write-one-to-clear
    clear_all(); pulse(6'h2D);
    wr(2'd0, 32'h0); rd(2'd0, d); chk("R4 zero write keeps", d, 32'h2D);
    wr(2'd0, 32'h09); rd(2'd0, d); chk("R4 selective clear", d, 32'h24);

    // R5 set wins over clear
    clear_all();
    @(negedge clk); evt_set = 6'h04; reg_addr = 2'd0; reg_wdata = 32'h04; reg_wr = 1'b1;
    @(negedge clk); evt_set = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd0, d); chk("R5 set wins", d, 32'h04);

    // R7/R8: code 2 gives 4 ticks
    clear_all(); wr(2'd1, 32'h3F); wr(2'd2, 32'd2);
    pulse(6'h01);
    repeat (3) tick();
    @(negedge clk); chk("R7 no irq before boundary", 32'(irq_o), 0);
    tick(); @(negedge clk);
    chk("R7 irq after boundary", 32'(irq_o), 1);

    // R10 hold until all cleared
    pulse(6'h04);
    wr(2'd0, 32'h01); @(negedge clk);
    chk("R10 irq held by remaining source", 32'(irq_o), 1);
    wr(2'd0, 32'h04); @(negedge clk);
    chk("R10 irq falls after last clear", 32'(irq_o), 0);

    // R9 clear before boundary
    clear_all(); wr(2'd2, 32'd2);
    pulse(6'h02);
    repeat (2) tick();
    wr(2'd0, 32'h02);
    repeat (2) tick();
    @(negedge clk);
    chk("R9 cleared before boundary", 32'(irq_o), 0);

    // R8 code 0: every tick is a boundary
    clear_all(); wr(2'd2, 32'd0);
    pulse(6'h20); @(negedge clk);
    chk("R8 code0 before tick", 32'(irq_o), 0);
    tick(); @(negedge clk);
    chk("R8 code0 after one tick", 32'(irq_o), 1);

    // R8 code 7 saturates to 64
    clear_all(); wr(2'd2, 32'd7);
    pulse(6'h01);
    repeat (63) tick();
    @(negedge clk); chk("R8 code7 no irq at 63", 32'(irq_o), 0);
    tick(); @(negedge clk);
    chk("R8 code7 irq at 64", 32'(irq_o), 1);

    // R11 enable removal
    clear_all(); pulse(6'h08); @(negedge clk);
    chk("R11 irq before disable", 32'(irq_o), 1);
    wr(2'd1, 32'h0); @(negedge clk);
    chk("R11 irq after disable", 32'(irq_o), 0);
    rd(2'd0, d); chk("R11 status kept", d, 32'h08);

    // R3 disabled deferred source through a boundary
    clear_all(); wr(2'd1, 32'h3E); wr(2'd2, 32'd0);
    pulse(6'h01); tick(); @(negedge clk);
    chk("R3 disabled deferred silent", 32'(irq_o), 0);
    rd(2'd0, d); chk("R3 disabled still polled", d, 32'h01);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule